// File: doc/BRIEF.md
# Strand Pause Timer

This block holds one execution strand stalled for a requested number of clock cycles. Software writes a cycle count through a single-cycle write strobe. From the next cycle the block raises its stall output and keeps it high for that count, rounded down to a multiple of eight. A small value gives a stall of one cycle. An asynchronous-event input, such as a disrupting trap, ends the stall early.

Time is kept coarsely. The written word is divided by eight, which drops its three low bits, and the result is loaded into a wide down-counter. A three-bit prescaler steps this counter once every eight stalled cycles. A write that arrives during a stall replaces the pending count and restarts the prescaler. Each release, whether the count ran out or a trap ended it, is marked by a one-cycle pulse.

Top module: `pause_timer`

## Requirements
- R1: During and right after reset, `stall_o` and `release_o` are both 0.
- R2: A write (`wr_en_i`=1) drives `stall_o` high starting in the cycle after the write edge.
- R3: When `wr_data_i` >= 8, `stall_o` stays high for exactly 8*floor(`wr_data_i`/8) cycles. The three low bits of the word have no effect on this length.
- R4: When `wr_data_i` < 8, including 0, `stall_o` is high for exactly one cycle.
- R5: When a stall ends because its count runs out, `release_o` is 1 in the first cycle that `stall_o` is low, and it is 0 in the cycle after that.
- R6: If `trap_i` is 1 on an edge while `stall_o` is high and no write occurs, then in the next cycle `stall_o` is 0 and `release_o` is 1.
- R7: `trap_i` has no effect while the strand is not stalled. Both outputs stay 0.
- R8: A write during a stall restarts timing from the new value. The stall then lasts exactly as R3 or R4 gives for the new value, and `release_o` stays 0 until that new stall ends.
- R9: When a write and a trap arrive on the same edge, the write wins. A new stall begins and no release pulse is produced.
- R10: The count keeps all 61 bits of `wr_data_i`/8. A write with only bit 63 set produces a long stall, not a one-cycle stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Pause-request write strobe, one cycle |
| wr_data_i | input | 64 | Requested stall length in cycles |
| trap_i | input | 1 | Disrupting event that aborts a stall |
| stall_o | output | 1 | Strand is held |
| release_o | output | 1 | One-cycle pulse when a stall ends |

## Verification
The assertions assume that all inputs are 0 or 1 from the first clock edge after reset. They also assume the write strobe is a synchronous level, sampled only on rising edges. Properties that look back one cycle depend on this so that they see defined history. The stimulus drives every input to a known idle value at time zero and holds it there through reset. After that it changes inputs only on falling edges, and it raises the write strobe and the trap for one cycle at a time, except where the test deliberately makes them coincide.

// File: rtl/pause_pkg.sv
package pause_pkg;

    // Default width of the written request word.
    localparam int unsigned REQ_W_DEF   = 64;
    // Default log2 of the prescaler grain (8 cycles).
    localparam int unsigned GRAIN_L_DEF = 3;

    // Per-cycle control decoded from the edge inputs.
    typedef struct packed {
        logic load;       // accept a new request
        logic short_req;  // request below one grain
        logic abort;      // trap ends a running stall
    } pause_ctl_t;

    // Decode the control word from the inputs and the current busy state.
    function automatic pause_ctl_t decode_ctl(
        input logic wr,
        input logic upper_zero,
        input logic trap,
        input logic busy
    );
        pause_ctl_t c;
        c.load      = wr;
        c.short_req = wr & upper_zero;
        c.abort     = trap & busy & ~wr;
        return c;
    endfunction

endpackage

// File: rtl/pause_prescale.sv
module pause_prescale #(
    parameter int unsigned W = 3
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         restart_i,
    input  logic [W-1:0] restart_val_i,
    input  logic         run_i,
    output logic         tick_o
);
    logic [W-1:0] phase_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= '0;
        end else if (restart_i) begin
            phase_q <= restart_val_i;
        end else if (run_i) begin
            phase_q <= phase_q + W'(1);
        end
    end

    // The tick fires on the last phase of each grain.
    assign tick_o = run_i && !restart_i && (phase_q == {W{1'b1}});
endmodule

// File: rtl/pause_count.sv
module pause_count #(
    parameter int unsigned W = 61
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         clear_i,
    input  logic         dec_i,
    output logic         busy_o,
    output logic         last_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (dec_i && busy_o) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign busy_o = (cnt_q != '0);
    assign last_o = (cnt_q == W'(1));
endmodule

// File: rtl/pause_timer.sv
module pause_timer
    import pause_pkg::*;
#(
    parameter int unsigned REQ_W   = REQ_W_DEF,
    parameter int unsigned GRAIN_L = GRAIN_L_DEF
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic [REQ_W-1:0] wr_data_i,
    input  logic             trap_i,
    output logic             stall_o,
    output logic             release_o
);
    localparam int unsigned CNT_W = REQ_W - GRAIN_L;

    logic [CNT_W-1:0]   scaled;
    logic [CNT_W-1:0]   load_val;
    logic [GRAIN_L-1:0] phase_init;
    logic               busy;
    logic               last;
    logic               tick;
    logic               release_q;
    pause_ctl_t         ctl;

    assign scaled = wr_data_i[REQ_W-1:GRAIN_L];
    assign ctl    = decode_ctl(wr_en_i, (scaled == '0), trap_i, busy);

    // A short request loads one grain and starts on its last phase,
    // so exactly one stalled cycle elapses.
    assign load_val   = ctl.short_req ? CNT_W'(1) : scaled;
    assign phase_init = ctl.short_req ? {GRAIN_L{1'b1}} : '0;

    pause_prescale #(.W(GRAIN_L)) u_prescale (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .restart_i     (ctl.load),
        .restart_val_i (phase_init),
        .run_i         (busy),
        .tick_o        (tick)
    );

    pause_count #(.W(CNT_W)) u_count (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (ctl.load),
        .load_val_i (load_val),
        .clear_i    (ctl.abort),
        .dec_i      (tick),
        .busy_o     (busy),
        .last_o     (last)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            release_q <= 1'b0;
        end else begin
            release_q <= ctl.abort || (tick && last && !ctl.load);
        end
    end

    assign stall_o   = busy;
    assign release_o = release_q;
endmodule

// File: rtl/pause_timer_chk.sv
module pause_timer_chk #(
    parameter int unsigned REQ_W   = 64,
    parameter int unsigned GRAIN_L = 3
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             wr_en_i,
    input logic [REQ_W-1:0] wr_data_i,
    input logic             trap_i,
    input logic             stall_o,
    input logic             release_o
);
    logic short_wr;
    assign short_wr = wr_en_i && (wr_data_i[REQ_W-1:GRAIN_L] == '0);

    AST_STALL_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_en_i |=> stall_o); // R2

    AST_SHORT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (stall_o && $past(short_wr) && !wr_en_i) |=> !stall_o); // R4

    AST_RELEASE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        release_o |=> !release_o); // R5

    AST_RELEASE_AFTER_STALL: assert property (@(posedge clk_i) disable iff (rst_i)
        release_o |-> (!stall_o && $past(stall_o))); // R5

    AST_TRAP_RELEASES: assert property (@(posedge clk_i) disable iff (rst_i)
        (trap_i && stall_o && !wr_en_i) |=> (!stall_o && release_o)); // R6

    AST_IDLE_TRAP_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (!stall_o && !wr_en_i) |=> (!stall_o && !release_o)); // R7

    AST_WRITE_BEATS_TRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && trap_i) |=> (stall_o && !release_o)); // R9
endmodule

bind pause_timer pause_timer_chk #(.REQ_W(REQ_W), .GRAIN_L(GRAIN_L)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .trap_i    (trap_i),
    .stall_o   (stall_o),
    .release_o (release_o)
);

// File: tb/test_pause_timer.sv
module test_pause_timer;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        trap = 1'b0;
    logic        stall;
    logic        rel;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pause_timer i_pause_timer (
        .clk_i     (clk),
        .rst_i     (rst),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .trap_i    (trap),
        .stall_o   (stall),
        .release_o (rel)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive a one-cycle write; returns at the first falling edge after it.
    task automatic do_write(input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    // Count stalled falling edges from now; report release at the first low one.
    task automatic measure(output int n, output int rel_at_end, output int rel_during);
        n = 0; rel_during = 0;
        while (stall && n < 4000) begin
            if (rel) rel_during++;
            n++;
            @(negedge clk);
        end
        rel_at_end = int'(rel);
    endtask

    task automatic t_reset();
        check("R1", "stall in reset", stall, 0);
        check("R1", "release in reset", rel, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1", "stall after reset", stall, 0);
        check("R1", "release after reset", rel, 0);
    endtask

    task automatic t_length(input logic [63:0] d, input int exp_len, input string req);
        int n, re, rd;
        do_write(d);
        check("R2", "stall right after write", stall, 1);
        measure(n, re, rd);
        check(req, "stall length", n, exp_len);
        check("R5", "release at end", re, 1);
        check("R5", "release early", rd, 0);
        @(negedge clk);
        check("R5", "release width", rel, 0);
    endtask

    task automatic t_trap_abort();
        do_write(64'd800);
        repeat (20) @(negedge clk);
        trap = 1'b1;
        @(negedge clk);
        trap = 1'b0;
        check("R6", "stall after trap", stall, 0);
        check("R6", "release on trap", rel, 1);
        @(negedge clk);
        check("R6", "release width after trap", rel, 0);
    endtask

    task automatic t_idle_trap();
        trap = 1'b1;
        @(negedge clk);
        trap = 1'b0;
        check("R7", "stall after idle trap", stall, 0);
        check("R7", "release after idle trap", rel, 0);
    endtask

    task automatic t_rewrite();
        int n, re, rd;
        do_write(64'd80);
        repeat (10) @(negedge clk);
        do_write(64'd24);
        measure(n, re, rd);
        check("R8", "length after rewrite", n, 24);
        check("R8", "release before end", rd, 0);
        check("R8", "release at end", re, 1);
        do_write(64'd800);
        repeat (5) @(negedge clk);
        do_write(64'd3);
        measure(n, re, rd);
        check("R8", "short rewrite length", n, 1);
        @(negedge clk);
    endtask

    task automatic t_write_trap();
        int n, re, rd;
        do_write(64'd800);
        repeat (7) @(negedge clk);
        wr_en = 1'b1; wr_data = 64'd16; trap = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; trap = 1'b0;
        check("R9", "stall after write+trap", stall, 1);
        check("R9", "no release on write+trap", rel, 0);
        measure(n, re, rd);
        check("R9", "length after write+trap", n, 16);
        @(negedge clk);
    endtask

    task automatic t_wide();
        do_write(64'h8000_0000_0000_0000);
        repeat (100) @(negedge clk);
        check("R10", "stall with top bit only", stall, 1);
        trap = 1'b1;
        @(negedge clk);
        trap = 1'b0;
        check("R10", "released by trap", stall, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_length(64'd8,   8,  "R3");
        t_length(64'd15,  8,  "R3");
        t_length(64'd100, 96, "R3");
        t_length(64'd5,   1,  "R4");
        t_length(64'd0,   1,  "R4");
        t_trap_abort();
        t_idle_trap();
        t_rewrite();
        t_write_trap();
        t_wide();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule